// File: doc/BRIEF.md
# Row and Frame Readout Window Counter

This block produces the readout window timing for an image sensor core. A row-start sync opens a row. From the next clock a pixel-valid strobe stays high while a pixel counter advances once per clock. The strobe drops once the counter has matched a 12-bit pixel limit. Two pixels leave the core on every clock, so software programs the pixel limit as (region width / 2) − 1. A frame-start sync clears a line counter. Each row-clock pulse then advances that counter. The pulse that arrives while the counter equals a 12-bit line limit raises a last-line strobe for exactly one clock. The line limit is therefore the number of lines wanted minus one.

Both limits arrive on plain parallel inputs. Each limit is captured only when its own sync arrives, so a write during a window takes effect at the next row or frame. Two independent state machines do the work.

The pixel machine has states PX_IDLE and PX_ACTIVE. It moves PX_IDLE→PX_ACTIVE on row sync. It stays in PX_ACTIVE on a restart (row sync again) or while the count is below the limit. It moves PX_ACTIVE→PX_IDLE when the count equals the limit and no row sync is present.

The line machine has states LN_IDLE, LN_RUN, LN_LAST and LN_HOLD. Frame sync moves any state to LN_RUN. In LN_RUN, a row clock at count = limit moves to LN_LAST; a row clock below the limit increments the count and stays. LN_LAST moves to LN_HOLD after one clock. LN_HOLD stays until the next frame sync.

Top module: `readout_window_timer`

## Requirements
- R1: While reset is asserted and right after it is released, pix_valid and last_line are 0.
- R2: A row_sync sampled at clock edge k holds pix_valid high for exactly P+1 clocks, starting after edge k, where P is the pixel limit captured at edge k. pix_valid then goes low.
- R3: A pixel limit of 0 gives a pix_valid window of exactly one clock.
- R4: A row_sync while pix_valid is high restarts the window: the counter returns to 0 and the window runs for the newly captured limit plus one clock from that edge.
- R5: pix_limit_in is captured only on a row_sync edge; changing it during a window does not change that window's length.
- R6: After frame_sync with line limit L, last_line is high for exactly one clock. It rises after the edge that samples the (L+1)th row_clk pulse.
- R7: A line limit of 0 makes the first row_clk pulse after frame_sync raise last_line.
- R8: After last_line, further row_clk pulses raise no further last_line until the next frame_sync.
- R9: frame_sync restarts the line count in any state and takes priority over a row_clk in the same clock; that row_clk is not counted.
- R10: line_limit_in is captured only on a frame_sync edge; changing it during a frame does not move last_line.
- R11: row_clk pulses after reset but before any frame_sync never raise last_line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sync | input | 1 | Row-start sync, one-clock pulse |
| frame_sync | input | 1 | Frame-start sync, one-clock pulse |
| row_clk | input | 1 | Row-advance pulse, one clock per line |
| pix_limit_in | input | 12 | Pixel limit, (width/2)−1 |
| line_limit_in | input | 12 | Line limit, lines−1 |
| pix_valid | output | 1 | High during the pixel readout window |
| last_line | output | 1 | One-clock pulse on the final line |

## Verification
Directed windows with pixel limits of 0, 1 and 7 separate an off-by-one in the end compare from a correct one. A restart in the middle of a window, together with a limit change in the middle of a window, shows whether the counter clears and whether the limit is captured only at sync. Line frames with limits 0 and 3, extra row clocks after the end, simultaneous frame sync and row clock, and row clocks with no frame sync separate the hold state, the sync priority and the idle behaviour. Seeded random traffic with overlapping syncs and small limits is then compared each clock against a bench reference model of both windows.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
    typedef enum logic {
        PX_IDLE,
        PX_ACTIVE
    } px_state_t;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_RUN,
        LN_LAST,
        LN_HOLD
    } ln_state_t;
endpackage

// File: rtl/rdw_pixel_seq.sv
module rdw_pixel_seq
    import rdw_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_sync,
    input  logic [CNT_W-1:0] limit_in,
    output logic             pix_valid
);
    px_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        unique case (state_q)
            PX_IDLE: begin
                if (row_sync) begin
                    state_d = PX_ACTIVE;
                    cnt_d   = '0;
                    lim_d   = limit_in;
                end
            end
            PX_ACTIVE: begin
                if (row_sync) begin
                    cnt_d = '0;
                    lim_d = limit_in;
                end else if (cnt_q == lim_q) begin
                    state_d = PX_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PX_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        pix_valid = (state_q == PX_ACTIVE);
    end

    // R2
    px_open_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_sync |=> (pix_valid && cnt_q == '0));

    // R2
    px_hold_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !row_sync && cnt_q != lim_q) |=> pix_valid);

    // R2
    px_close_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !row_sync && cnt_q == lim_q) |=> !pix_valid);

    // R5
    px_limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_sync |=> $stable(lim_q));

    // R2
    px_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (cnt_q <= lim_q));
endmodule

// File: rtl/rdw_line_seq.sv
module rdw_line_seq
    import rdw_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             row_clk,
    input  logic [CNT_W-1:0] limit_in,
    output logic             last_line
);
    ln_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        if (frame_sync) begin
            state_d = LN_RUN;
            cnt_d   = '0;
            lim_d   = limit_in;
        end else begin
            unique case (state_q)
                LN_IDLE: state_d = LN_IDLE;
                LN_RUN: begin
                    if (row_clk) begin
                        if (cnt_q == lim_q) state_d = LN_LAST;
                        else                cnt_d   = cnt_q + 1'b1;
                    end
                end
                LN_LAST: state_d = LN_HOLD;
                LN_HOLD: state_d = LN_HOLD;
                default: state_d = LN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        last_line = (state_q == LN_LAST);
    end

    // R6
    ln_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_line |=> !last_line);

    // R9
    ln_sync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (!last_line && cnt_q == '0 && state_q == LN_RUN));

    // R8
    ln_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_HOLD && !frame_sync) |=> !last_line);

    // R11
    ln_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_IDLE && !frame_sync) |=> !last_line);

    // R10
    ln_limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(lim_q));
endmodule

// File: rtl/readout_window_timer.sv
module readout_window_timer #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_sync,
    input  logic              frame_sync,
    input  logic              row_clk,
    input  logic [PIX_W-1:0]  pix_limit_in,
    input  logic [LINE_W-1:0] line_limit_in,
    output logic              pix_valid,
    output logic              last_line
);
    rdw_pixel_seq #(.CNT_W(PIX_W)) u_pixel (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_sync  (row_sync),
        .limit_in  (pix_limit_in),
        .pix_valid (pix_valid)
    );

    rdw_line_seq #(.CNT_W(LINE_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .row_clk    (row_clk),
        .limit_in   (line_limit_in),
        .last_line  (last_line)
    );

    // R1
    out_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pix_valid && !last_line));
endmodule

// File: tb/readout_window_timer_bench.sv
module readout_window_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_sync = 1'b0;
    logic        frame_sync = 1'b0;
    logic        row_clk = 1'b0;
    logic [11:0] pix_limit_in = '0;
    logic [11:0] line_limit_in = '0;
    logic        pix_valid;
    logic        last_line;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit          m_pv;
    logic [11:0] m_pc, m_pl;
    int          m_ls;
    logic [11:0] m_lc, m_ll;

    always #5 clk = ~clk;

    readout_window_timer u_readout_window_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .row_sync      (row_sync),
        .frame_sync    (frame_sync),
        .row_clk       (row_clk),
        .pix_limit_in  (pix_limit_in),
        .line_limit_in (line_limit_in),
        .pix_valid     (pix_valid),
        .last_line     (last_line)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pv = 0; m_pc = '0; m_pl = '0;
            m_ls = 0; m_lc = '0; m_ll = '0;
        end else begin
            if (row_sync) begin
                m_pv = 1; m_pc = '0; m_pl = pix_limit_in;
            end else if (m_pv) begin
                if (m_pc == m_pl) m_pv = 0;
                else m_pc = m_pc + 12'd1;
            end
            if (frame_sync) begin
                m_ls = 1; m_lc = '0; m_ll = line_limit_in;
            end else if (m_ls == 1) begin
                if (row_clk) begin
                    if (m_lc == m_ll) m_ls = 2;
                    else m_lc = m_lc + 12'd1;
                end
            end else if (m_ls == 2) begin
                m_ls = 3;
            end
        end
    end

    function automatic bit exp_pv();
        return m_pv;
    endfunction

    function automatic bit exp_ll();
        return (m_ls == 2);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit rs, input bit fs, input bit rc,
                        input logic [11:0] pl, input logic [11:0] ll);
        @(negedge clk);
        if (rst_n) begin
            check("R2 model pix_valid", int'(pix_valid), int'(exp_pv()));
            check("R6 model last_line", int'(last_line), int'(exp_ll()));
        end
        row_sync = rs; frame_sync = fs; row_clk = rc;
        pix_limit_in = pl; line_limit_in = ll;
    endtask

    task automatic pixel_window(input string tag, input logic [11:0] lim);
        int highs = 0;
        step(1, 0, 0, lim, 0);
        for (int i = 0; i < int'(lim) + 4; i++) begin
            step(0, 0, 0, lim, 0);
            if (pix_valid) highs++;
        end
        check(tag, highs, int'(lim) + 1);
    endtask

    task automatic line_frame(input string tag, input logic [11:0] lim,
                              input logic [11:0] alt, input int extra);
        int hits = 0;
        int at = -1;
        step(0, 1, 0, 0, lim);
        for (int k = 0; k < int'(lim) + 1 + extra; k++) begin
            step(0, 0, 1, 0, alt);
            if (last_line) hits++;
            step(0, 0, 0, 0, alt);
            if (last_line) begin hits++; at = k; end
        end
        check({tag, " pulse count"}, hits, 1);
        check({tag, " pulse index"}, at, int'(lim));
    endtask

    initial begin
        int highs;
        int hits;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        check("R1 pix_valid in reset", int'(pix_valid), 0);
        check("R1 last_line in reset", int'(last_line), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);
        check("R1 pix_valid after reset", int'(pix_valid), 0);
        check("R1 last_line after reset", int'(last_line), 0);

        // R11: row clocks with no frame sync
        hits = 0;
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 1, 0, 0);
            if (last_line) hits++;
            step(0, 0, 0, 0, 0);
            if (last_line) hits++;
        end
        check("R11 no pulse before frame sync", hits, 0);

        pixel_window("R2 window limit 7", 12'd7);
        pixel_window("R2 window limit 1", 12'd1);
        pixel_window("R3 window limit 0", 12'd0);

        // R5: limit changed in mid window
        highs = 0;
        step(1, 0, 0, 12'd5, 0);
        for (int i = 0; i < 10; i++) begin
            step(0, 0, 0, 12'd1, 0);
            if (pix_valid) highs++;
        end
        check("R5 mid-window limit ignored", highs, 6);

        // R4: restart after three high cycles with new limit 2
        highs = 0;
        step(1, 0, 0, 12'd6, 0);
        for (int i = 0; i < 14; i++) begin
            step(i == 2, 0, 0, 12'd2, 0);
            if (pix_valid) highs++;
        end
        check("R4 restart window length", highs, 6);

        line_frame("R6 limit 3", 12'd3, 12'd3, 3);
        line_frame("R7 limit 0", 12'd0, 12'd0, 3);
        line_frame("R8 extra row clocks", 12'd2, 12'd2, 5);
        line_frame("R10 mid-frame limit ignored", 12'd4, 12'd1, 2);

        // R9: frame sync with row clock in same cycle, mid frame
        hits = 0;
        step(0, 1, 0, 0, 12'd2);
        step(0, 0, 1, 0, 12'd2);
        step(0, 0, 0, 0, 12'd2);
        step(0, 1, 1, 0, 12'd2);
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 1, 0, 12'd2);
            if (last_line) hits++;
            step(0, 0, 0, 0, 12'd2);
            if (last_line) hits = hits + ((k == 2) ? 1 : 100);
        end
        check("R9 sync priority and restart", hits, 1);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 100) < 6, ($urandom % 100) < 2, ($urandom % 100) < 25,
                 12'($urandom % 12), 12'($urandom % 10));
        end
        step(0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule